// File: doc/BRIEF.md
# SPI Register Slave with Byte-Level Flow Control

This block lets an SPI host (clock mode 0, most significant bit first) read and write registers that sit behind a back-end port whose read latency is not known in advance. The host pulls the active-low select low. It then sends a command byte, followed by a single address byte. For a write, the next byte carries the data. For a read, the slave cannot know how long the back end will take, so it answers with flow-control bytes: a busy code for as long as no data is held, then a ready code, then the data byte.

Every SPI pin enters through a chain of synchronising flops. Clock edges are detected in the system clock domain, which must run at least four times faster than the serial clock. The back-end read port uses a simple handshake. The request is a level that stays high until a one-cycle valid pulse returns the data. Writes leave the block as a one-cycle strobe carrying the address and the data. Raising the select at any point abandons the frame.

Top module: `spi_flow_slave`

## Requirements
- R1: Bits are sampled on the rising serial clock edge and launched after the falling edge, most significant bit first. While the command byte and the address byte are being received, the slave returns 0xFF.
- R2: Command 0x03 is a read. When its address byte completes, `rd_req` rises with `rd_addr` equal to that address. `rd_req` stays high until `rd_valid` is seen.
- R3: After a read address, the slave returns busy bytes of 0xFF until the data is held. There is always at least one busy byte.
- R4: The first byte decided after the data is held is the ready code 0x00. The byte after it is the read data.
- R5: The busy or ready choice is made only at byte boundaries. If data arrives during a busy byte, that byte still completes as 0xFF and the next byte is 0x00.
- R6: Command 0x02 is a write. The slave returns 0x00 while receiving the data byte. It then pulses `wr_stb` for exactly one cycle with `wr_addr` and `wr_data`.
- R7: Any other command makes the slave return 0xFF for the rest of the frame, with no read request and no write strobe.
- R8: Deasserting `cs_n` aborts the frame and drops `rd_req`. The next frame is then served normally from its command byte.
- R9: After reset and while deselected, `miso` is 1, `rd_req` is 0 and `wr_stb` is 0.
- R10: Once the read or write data byte is done, further bytes in the same frame return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host, idles low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| rd_req | output | 1 | Read request level, held until `rd_valid` |
| rd_addr | output | 8 | Read address |
| rd_valid | input | 1 | One-cycle pulse with read data |
| rd_data | input | 8 | Read data, taken when `rd_valid` is high |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write data |

## Verification
The bench uses the default parameters: two synchronising stages, read command 0x03, write command 0x02, busy 0xFF and ready 0x00. It drives the serial clock at one sixteenth of the system clock, so one byte spans 128 system cycles. A back-end model then answers with latencies from one cycle up to several hundred cycles. This covers three cases: data landing inside the first busy byte, data landing right at a byte boundary, and waits of three or four busy bytes. A latency far larger than any frame leaves the request pending, so an abort while waiting can be observed.

// File: rtl/spi_flow_pkg.sv
package spi_flow_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W);

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ADDR,
      ST_WAIT,
      ST_READY,
      ST_RDATA,
      ST_WDATA,
      ST_TAIL
   } frame_st_e;
endpackage

// File: rtl/spi_flow_sync.sv
module spi_flow_sync #(
   parameter int              STAGES  = 2,
   parameter int              WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("spi_flow_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d_in;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign d_out = chain[STAGES-1];
endmodule

// File: rtl/spi_flow_edge.sv
module spi_flow_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_s,
   input  logic cs_n_s,
   output logic active,
   output logic rise,
   output logic fall
);
   logic sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign active = ~cs_n_s;
   assign rise   = active &  sclk_s & ~sclk_d;
   assign fall   = active & ~sclk_s &  sclk_d;
endmodule

// File: rtl/spi_flow_shift.sv
module spi_flow_shift
   import spi_flow_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  active,
   input  logic  rise,
   input  logic  fall,
   input  logic  mosi_s,
   input  byte_t tx_next,
   output logic  byte_done,
   output byte_t rx_byte,
   output logic  miso
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   logic [CNT_W-1:0] bit_cnt;
   byte_t            rx_sh;
   byte_t            tx_sh;
   byte_t            rx_full;

   assign rx_full = {rx_sh[BYTE_W-2:0], mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         rx_byte   <= '0;
         tx_sh     <= '1;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (!active) begin
            bit_cnt <= '0;
            tx_sh   <= '1;
         end else begin
            if (rise) begin
               rx_sh <= rx_full;
               if (bit_cnt == LAST_BIT) begin
                  bit_cnt   <= '0;
                  byte_done <= 1'b1;
                  rx_byte   <= rx_full;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            if (fall) begin
               if (bit_cnt == '0) tx_sh <= tx_next;
               else               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
            end
         end
      end
   end

   assign miso = tx_sh[BYTE_W-1];
endmodule

// File: rtl/spi_flow_ctrl.sv
module spi_flow_ctrl
   import spi_flow_pkg::*;
#(
   parameter byte_t OP_READ  = 8'h03,
   parameter byte_t OP_WRITE = 8'h02,
   parameter byte_t FC_BUSY  = 8'hFF,
   parameter byte_t FC_READY = 8'h00
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  active,
   input  logic  byte_done,
   input  byte_t rx_byte,
   input  logic  rd_valid,
   input  byte_t rd_data,
   output logic  rd_req,
   output byte_t rd_addr,
   output logic  wr_stb,
   output byte_t wr_addr,
   output byte_t wr_data,
   output byte_t tx_next
);
   frame_st_e state;
   logic      is_read;
   logic      have_data;
   byte_t     data_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_CMD;
         is_read   <= 1'b0;
         have_data <= 1'b0;
         data_hold <= '0;
         rd_req    <= 1'b0;
         rd_addr   <= '0;
         wr_stb    <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         tx_next   <= FC_BUSY;
      end else begin
         wr_stb <= 1'b0;
         if (rd_req && rd_valid) begin
            rd_req    <= 1'b0;
            have_data <= 1'b1;
            data_hold <= rd_data;
         end
         if (!active) begin
            state     <= ST_CMD;
            rd_req    <= 1'b0;
            have_data <= 1'b0;
            tx_next   <= FC_BUSY;
         end else if (byte_done) begin
            unique case (state)
               ST_CMD: begin
                  tx_next <= FC_BUSY;
                  is_read <= (rx_byte == OP_READ);
                  if (rx_byte == OP_READ || rx_byte == OP_WRITE) state <= ST_ADDR;
                  else                                           state <= ST_TAIL;
               end
               ST_ADDR: begin
                  if (is_read) begin
                     rd_req  <= 1'b1;
                     rd_addr <= rx_byte;
                     tx_next <= FC_BUSY;
                     state   <= ST_WAIT;
                  end else begin
                     wr_addr <= rx_byte;
                     tx_next <= FC_READY;
                     state   <= ST_WDATA;
                  end
               end
               ST_WAIT: begin
                  if (have_data) begin
                     tx_next <= FC_READY;
                     state   <= ST_READY;
                  end else begin
                     tx_next <= FC_BUSY;
                  end
               end
               ST_READY: begin
                  tx_next <= data_hold;
                  state   <= ST_RDATA;
               end
               ST_RDATA: begin
                  tx_next <= FC_BUSY;
                  state   <= ST_TAIL;
               end
               ST_WDATA: begin
                  wr_stb  <= 1'b1;
                  wr_data <= rx_byte;
                  tx_next <= FC_BUSY;
                  state   <= ST_TAIL;
               end
               default: begin
                  tx_next <= FC_BUSY;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/spi_flow_slave.sv
module spi_flow_slave
   import spi_flow_pkg::*;
#(
   parameter int    SYNC_STAGES = 2,
   parameter byte_t OP_READ     = 8'h03,
   parameter byte_t OP_WRITE    = 8'h02,
   parameter byte_t FC_BUSY     = 8'hFF,
   parameter byte_t FC_READY    = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       cs_n,
   input  logic       mosi,
   output logic       miso,
   output logic       rd_req,
   output logic [7:0] rd_addr,
   input  logic       rd_valid,
   input  logic [7:0] rd_data,
   output logic       wr_stb,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data
);
   generate
      if (OP_READ == OP_WRITE) begin : g_bad_ops
         $error("spi_flow_slave: read and write commands must differ");
      end
      if (FC_BUSY == FC_READY) begin : g_bad_fc
         $error("spi_flow_slave: busy and ready codes must differ");
      end
   endgenerate

   logic [2:0] pins_raw, pins_s;
   logic       sclk_s, cs_n_s, mosi_s;
   logic       cs_active, sck_rise, sck_fall;
   logic       byte_done;
   byte_t      rx_byte, tx_next;

   assign pins_raw = {sclk, cs_n, mosi};

   spi_flow_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (3),
      .RST_VAL(3'b010)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in (pins_raw),
      .d_out(pins_s)
   );

   assign {sclk_s, cs_n_s, mosi_s} = pins_s;

   spi_flow_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sclk_s(sclk_s),
      .cs_n_s(cs_n_s),
      .active(cs_active),
      .rise  (sck_rise),
      .fall  (sck_fall)
   );

   spi_flow_shift u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (cs_active),
      .rise     (sck_rise),
      .fall     (sck_fall),
      .mosi_s   (mosi_s),
      .tx_next  (tx_next),
      .byte_done(byte_done),
      .rx_byte  (rx_byte),
      .miso     (miso)
   );

   spi_flow_ctrl #(
      .OP_READ (OP_READ),
      .OP_WRITE(OP_WRITE),
      .FC_BUSY (FC_BUSY),
      .FC_READY(FC_READY)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (cs_active),
      .byte_done(byte_done),
      .rx_byte  (rx_byte),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .rd_req   (rd_req),
      .rd_addr  (rd_addr),
      .wr_stb   (wr_stb),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .tx_next  (tx_next)
   );
endmodule

// File: rtl/spi_flow_chk.sv
module spi_flow_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_active,
   input logic rd_req,
   input logic rd_valid,
   input logic wr_stb,
   input logic miso
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid && cs_active) |=> rd_req); // R2

   AST_ABORT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_active |=> !rd_req); // R8

   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb); // R6

   AST_NO_WR_DURING_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !wr_stb); // R7

   AST_IDLE_MISO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_active && $past(!cs_active)) |-> miso); // R9
endmodule

bind spi_flow_slave spi_flow_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_active(cs_active),
   .rd_req   (rd_req),
   .rd_valid (rd_valid),
   .wr_stb   (wr_stb),
   .miso     (miso)
);

// File: tb/sim_spi_flow_slave.sv
`timescale 1ns/1ps
module sim_spi_flow_slave;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       cs_n = 1'b1;
   logic       mosi = 1'b0;
   logic       miso;
   logic       rd_req;
   logic [7:0] rd_addr;
   logic       rd_valid = 1'b0;
   logic [7:0] rd_data = 8'h00;
   logic       wr_stb;
   logic [7:0] wr_addr;
   logic [7:0] wr_data;

   int n_checks = 0;
   int n_fail   = 0;
   int lat_cfg  = 0;
   int wait_cnt = 0;
   int wr_seen  = 0;
   int req_seen = 0;
   logic [7:0] last_wa, last_wd, last_ra;
   logic       req_prev = 1'b0;
   logic       done = 1'b0;

   always #2 clk = ~clk;

   spi_flow_slave u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   function automatic logic [7:0] exp_data(input logic [7:0] a);
      return {a[3:0], a[7:4]} ^ 8'hA5;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // back-end model with programmable latency
   always @(negedge clk) begin
      rd_valid <= 1'b0;
      if (rd_req && !rd_valid) begin
         if (wait_cnt >= lat_cfg) begin
            rd_valid <= 1'b1;
            rd_data  <= exp_data(rd_addr);
            wait_cnt <= 0;
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end else if (!rd_req) begin
         wait_cnt <= 0;
      end
   end

   // observers
   always @(negedge clk) begin
      if (wr_stb) begin
         wr_seen++;
         last_wa = wr_addr;
         last_wd = wr_data;
      end
      if (rd_req && !req_prev) begin
         req_seen++;
         last_ra = rd_addr;
      end
      req_prev = rd_req;
   end

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic frame_start();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic frame_end();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   task automatic do_read(input logic [7:0] addr, input int lat, input int exact_busy);
      logic [7:0] r;
      int busy;
      int rq0;
      lat_cfg = lat;
      rq0 = req_seen;
      frame_start();
      spi_byte(8'h03, r); check(r == 8'hFF, "R1 cmd byte", r, 8'hFF);
      spi_byte(addr, r);  check(r == 8'hFF, "R1 addr byte", r, 8'hFF);
      busy = 0;
      spi_byte(8'h00, r);
      while (r == 8'hFF && busy < 40) begin
         busy++;
         spi_byte(8'h00, r);
      end
      check(req_seen == rq0 + 1 && last_ra == addr, "R2 request addr", last_ra, addr);
      check(busy >= 1, "R3 busy count min", busy, 1);
      check(busy >= lat / 128 && busy <= lat / 128 + 2, "R3 busy count range", busy, lat / 128 + 1);
      if (exact_busy > 0) check(busy == exact_busy, "R5 busy before ready", busy, exact_busy);
      check(r == 8'h00, "R4 ready code", r, 8'h00);
      spi_byte(8'h00, r); check(r == exp_data(addr), "R4 read data", r, exp_data(addr));
      spi_byte(8'h00, r); check(r == 8'hFF, "R10 tail after read", r, 8'hFF);
      frame_end();
   endtask

   task automatic do_write(input logic [7:0] addr, input logic [7:0] data);
      logic [7:0] r;
      int w0;
      w0 = wr_seen;
      frame_start();
      spi_byte(8'h02, r); check(r == 8'hFF, "R1 cmd byte", r, 8'hFF);
      spi_byte(addr, r);  check(r == 8'hFF, "R1 addr byte", r, 8'hFF);
      spi_byte(data, r);  check(r == 8'h00, "R6 ack during data", r, 8'h00);
      spi_byte(8'h5A, r); check(r == 8'hFF, "R10 tail after write", r, 8'hFF);
      frame_end();
      check(wr_seen == w0 + 1, "R6 one strobe", wr_seen - w0, 1);
      check(last_wa == addr && last_wd == data, "R6 write fields",
            {last_wa, last_wd}, {addr, data});
   endtask

   task automatic do_bad(input logic [7:0] op);
      logic [7:0] r;
      int w0, q0;
      w0 = wr_seen;
      q0 = req_seen;
      frame_start();
      for (int k = 0; k < 4; k++) begin
         spi_byte(k == 0 ? op : 8'h03, r);
         check(r == 8'hFF, "R7 bad command fill", r, 8'hFF);
      end
      frame_end();
      check(wr_seen == w0 && req_seen == q0, "R7 no access",
            (wr_seen - w0) + (req_seen - q0), 0);
   endtask

   task automatic do_abort(input logic [7:0] addr);
      logic [7:0] r;
      lat_cfg = 1000000;
      frame_start();
      spi_byte(8'h03, r);
      spi_byte(addr, r);
      spi_byte(8'h00, r);
      check(rd_req == 1'b1, "R2 request pending", rd_req, 1);
      cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
      check(rd_req == 1'b0, "R8 abort drops request", rd_req, 0);
      check(miso == 1'b1, "R9 idle miso", miso, 1);
      repeat (2 * HALF) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (5) @(negedge clk);
      check(miso == 1'b1 && rd_req == 1'b0 && wr_stb == 1'b0, "R9 in reset",
            {miso, rd_req, wr_stb}, 3'b100);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check(miso == 1'b1 && rd_req == 1'b0 && wr_stb == 1'b0, "R9 after reset",
            {miso, rd_req, wr_stb}, 3'b100);

      // directed corners
      do_read(8'h3C, 1, 1);     // data lands early inside first busy byte
      do_read(8'hC3, 60, 1);    // mid-byte arrival: R5
      do_read(8'h81, 300, 0);
      do_write(8'h10, 8'hE7);
      do_bad(8'h00);
      do_bad(8'hFF);
      do_abort(8'h44);
      do_read(8'h44, 5, 1);     // R8 next frame normal
      do_write(8'hFF, 8'h00);

      // constrained random
      for (int it = 0; it < 24; it++) begin
         int kind;
         logic [7:0] a, d, op;
         kind = int'($urandom_range(0, 5));
         a = 8'($urandom);
         d = 8'($urandom);
         if (kind <= 2) begin
            do_read(a, int'($urandom_range(0, 450)), 0);
         end else if (kind <= 4) begin
            do_write(a, d);
         end else begin
            op = 8'($urandom);
            if (op == 8'h02 || op == 8'h03) op = 8'h7E;
            do_bad(op);
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule